// File: doc/BRIEF.md
# Serial Clock Source Detector

This block decides where an audio serial port's bit clock comes from. One input pin has two possible uses. A board can drive it with a running bit clock, or it can tie it to a fixed level that switches de-emphasis on or off. The block runs on the master clock and brings the shared pin and the frame (left/right) clock into that domain. It counts rising edges of the shared pin inside each half of the frame clock. When enough edges arrive within one half, it declares that an external bit clock is present.

The block starts in internal mode. In that mode the synchronized pin level is passed on as the de-emphasis enable. In external mode the de-emphasis enable is held low, whatever the pin does. The block falls back to internal mode when a set number of frame-clock rising edges go by with no rising edge on the shared pin. The circuit that generates the clock and the data shifter read the mode flag. They are outside this block.

Top module: `sclk_src_detect`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the mode output reads internal (`ext_sclk_mode` = 0, where 0 means internal and 1 means external), and `deemph_en` is 0 whatever the pin level.
- R2: Once EDGE_LIMIT rising edges of the shared pin (default 16) arrive within one frame-clock phase, the block switches to external mode. Extra edges in the same phase (30 in the test) leave it in external mode.
- R3: A phase with fewer than EDGE_LIMIT edges leaves the block in internal mode. The edge count restarts at every frame-clock transition, so edges split across two phases never add together.
- R4: Detection works the same in both phases. A burst inside a high phase and a burst inside a low phase each trigger external mode.
- R5: In internal mode, `deemph_en` follows the level of the shared pin within four master-clock cycles of a change on the pin.
- R6: In external mode, `deemph_en` is 0, even while the shared pin is held high.
- R7: In external mode, the block returns to internal mode after QUIET_FRAMES rising edges of the frame clock (default 2) with no rising edge on the shared pin.
- R8: In external mode, a rising edge on the shared pin restarts the quiet-frame count.
- R9: Falling edges of the frame clock do not advance the quiet-frame count.
- R10: A bit clock that keeps running across many frames holds the block in external mode, even when each phase carries fewer than EDGE_LIMIT edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; all state is in this domain |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Shared pin: external bit clock or de-emphasis level (asynchronous) |
| frame_clk_in | input | 1 | Frame (left/right) clock (asynchronous) |
| ext_sclk_mode | output | 1 | 1 = external bit clock in use, 0 = internal generation |
| deemph_en | output | 1 | De-emphasis enable; the pin level in internal mode, 0 in external mode |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, a threshold of 16 edges and a timeout of 2 quiet frames. With these values, the exact boundary between 15 and 16 edges can be reached with short bursts. A 2-frame timeout makes it possible to step through every frame-clock edge of a timeout one by one. This shows that a single rising edge is not enough, that falling edges are ignored, and that a pin edge in the middle of the timeout restarts the count.

// File: rtl/sclk_det_pkg.sv
package sclk_det_pkg;

    localparam int unsigned DEF_SYNC_STAGES  = 2;
    localparam int unsigned DEF_EDGE_LIMIT   = 16;
    localparam int unsigned DEF_QUIET_FRAMES = 2;

    // Which source currently supplies the serial bit clock
    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } clk_src_e;

    // Per-cycle events derived from the synchronized inputs
    typedef struct packed {
        logic pin_lvl;    // synchronized level of the shared pin
        logic pin_rise;   // shared pin went low to high
        logic frm_rise;   // frame clock went low to high
        logic frm_flip;   // frame clock changed level
    } line_evt_t;

    function automatic logic src_is_ext(clk_src_e s);
        return s == SRC_EXT;
    endfunction

endpackage

// File: rtl/sclk_det_sync.sv
module sclk_det_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/sclk_det_edges.sv
module sclk_det_edges
    import sclk_det_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_s,
    input  logic      frm_s,
    output line_evt_t evt
);

    logic pin_d;
    logic frm_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_d <= 1'b0;
            frm_d <= 1'b0;
        end else begin
            pin_d <= pin_s;
            frm_d <= frm_s;
        end
    end

    always_comb begin
        evt.pin_lvl  = pin_s;
        evt.pin_rise = pin_s & ~pin_d;
        evt.frm_rise = frm_s & ~frm_d;
        evt.frm_flip = frm_s ^ frm_d;
    end

endmodule

// File: rtl/sclk_det_phase_cnt.sv
module sclk_det_phase_cnt #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_rise,
    input  logic frm_flip,
    output logic hit
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP  = CW'(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (frm_flip) begin
            cnt <= '0;
        end else if (pin_rise && cnt != CAP) begin
            cnt <= cnt + CW'(1);
        end
    end

    // The edge that brings the count up to LIMIT within the current phase
    assign hit = pin_rise && !frm_flip && (cnt == LAST);

    // R3
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frm_flip |=> (cnt == '0));

endmodule

// File: rtl/sclk_det_quiet.sv
module sclk_det_quiet #(
    parameter int unsigned FRAMES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_rise,
    input  logic frm_rise,
    output logic expired
);

    localparam int unsigned QW = $clog2(FRAMES + 1);
    localparam logic [QW-1:0] CAP  = QW'(FRAMES);
    localparam logic [QW-1:0] LAST = QW'(FRAMES - 1);

    logic [QW-1:0] qcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            qcnt <= '0;
        end else if (pin_rise) begin
            qcnt <= '0;
        end else if (frm_rise && qcnt != CAP) begin
            qcnt <= qcnt + QW'(1);
        end
    end

    assign expired = frm_rise && !pin_rise && (qcnt == LAST);

    // R9: only rising frame edges may move the count
    quiet_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!frm_rise && !pin_rise) |=> $stable(qcnt));

endmodule

// File: rtl/sclk_det_mode.sv
module sclk_det_mode
    import sclk_det_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     enter_req,
    input  logic     exit_req,
    input  logic     pin_lvl,
    input  logic     pin_rise,
    output clk_src_e src,
    output logic     deemph
);

    clk_src_e state_q;
    clk_src_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            SRC_INT: if (enter_req) state_n = SRC_EXT;
            SRC_EXT: if (exit_req)  state_n = SRC_INT;
            default: state_n = SRC_INT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SRC_INT;
        else     state_q <= state_n;
    end

    assign src    = state_q;
    assign deemph = !src_is_ext(state_q) && pin_lvl;

    // R1
    rst_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == SRC_INT));

    // R2
    ext_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_INT && !enter_req) |=> (state_q == SRC_INT));

    // R7
    ext_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_EXT && !exit_req) |=> (state_q == SRC_EXT));

    // R8
    edge_holds_ext_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_EXT && pin_rise) |=> (state_q == SRC_EXT));

    // R6
    deemph_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SRC_EXT) |-> !deemph);

endmodule

// File: rtl/sclk_src_detect.sv
module sclk_src_detect
    import sclk_det_pkg::*;
#(
    parameter int unsigned SYNC_STAGES  = DEF_SYNC_STAGES,
    parameter int unsigned EDGE_LIMIT   = DEF_EDGE_LIMIT,
    parameter int unsigned QUIET_FRAMES = DEF_QUIET_FRAMES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic frame_clk_in,
    output logic ext_sclk_mode,
    output logic deemph_en
);

    logic [1:0] raw_in;
    logic [1:0] sync_out;
    line_evt_t  evt;
    logic       burst_hit;
    logic       quiet_done;
    clk_src_e   src;

    assign raw_in = {pin_in, frame_clk_in};

    sclk_det_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_out)
    );

    sclk_det_edges u_edges (
        .clk   (clk),
        .rst   (rst),
        .pin_s (sync_out[1]),
        .frm_s (sync_out[0]),
        .evt   (evt)
    );

    sclk_det_phase_cnt #(
        .LIMIT (EDGE_LIMIT)
    ) u_phase_cnt (
        .clk      (clk),
        .rst      (rst),
        .pin_rise (evt.pin_rise),
        .frm_flip (evt.frm_flip),
        .hit      (burst_hit)
    );

    sclk_det_quiet #(
        .FRAMES (QUIET_FRAMES)
    ) u_quiet (
        .clk      (clk),
        .rst      (rst),
        .pin_rise (evt.pin_rise),
        .frm_rise (evt.frm_rise),
        .expired  (quiet_done)
    );

    sclk_det_mode u_mode (
        .clk       (clk),
        .rst       (rst),
        .enter_req (burst_hit),
        .exit_req  (quiet_done),
        .pin_lvl   (evt.pin_lvl),
        .pin_rise  (evt.pin_rise),
        .src       (src),
        .deemph    (deemph_en)
    );

    assign ext_sclk_mode = src_is_ext(src);

endmodule

// File: tb/sclk_src_detect_tb.sv
module sclk_src_detect_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin = 1'b0;
    logic frm = 1'b0;
    logic ext_mode;
    logic deemph;

    int errs   = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sclk_src_detect u_dut (
        .clk           (clk),
        .rst           (rst),
        .pin_in        (pin),
        .frame_clk_in  (frm),
        .ext_sclk_mode (ext_mode),
        .deemph_en     (deemph)
    );

    typedef struct packed {
        logic [5:0] n_a;      // pulses in the starting phase
        logic [5:0] n_b;      // pulses after one frame-clock flip (none: no flip)
        logic       lr0;      // starting frame-clock level
        logic       exp_ext;  // expected mode afterwards
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{6'd0,  6'd0,  1'b0, 1'b0},   // R3 quiet pin
        '{6'd15, 6'd0,  1'b0, 1'b0},   // R3 one short of limit
        '{6'd16, 6'd0,  1'b0, 1'b1},   // R2 exact limit, low phase
        '{6'd16, 6'd0,  1'b1, 1'b1},   // R4 high phase
        '{6'd10, 6'd10, 1'b0, 1'b0},   // R3 split across phases
        '{6'd8,  6'd15, 1'b1, 1'b0},   // R3 split, second short
        '{6'd0,  6'd16, 1'b1, 1'b1},   // R4 limit in second phase
        '{6'd30, 6'd0,  1'b0, 1'b1},   // R2 well past limit
        '{6'd15, 6'd15, 1'b0, 1'b0}    // R3 two short phases
    };

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); pin = 1'b1;
            idle(3);
            pin = 1'b0;
            idle(2);
        end
    endtask

    task automatic flip_frame();
        @(negedge clk); frm = ~frm;
        idle(6);
    endtask

    task automatic do_reset(logic lr0);
        @(negedge clk);
        rst = 1'b1; pin = 1'b0; frm = lr0;
        idle(4);
        rst = 1'b0;
        idle(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state, pin high while in reset
        @(negedge clk); rst = 1'b1; pin = 1'b1;
        idle(5);
        check("R1 mode in reset", ext_mode, 1'b0);
        check("R1 deemph in reset", deemph, 1'b0);
        rst = 1'b0; pin = 1'b0;
        @(posedge clk); #1;
        check("R1 mode after release", ext_mode, 1'b0);
        idle(6);

        // Table walk: R2 R3 R4
        for (int i = 0; i < NV; i++) begin
            do_reset(VECS[i].lr0);
            pulses(int'(VECS[i].n_a));
            if (VECS[i].n_b != 0) begin
                flip_frame();
                pulses(int'(VECS[i].n_b));
            end
            idle(6);
            check($sformatf("R2/R3/R4 vector %0d", i), ext_mode, VECS[i].exp_ext);
        end

        // R5: internal mode passes the pin level
        do_reset(1'b0);
        pin = 1'b1; idle(4);
        check("R5 deemph high", deemph, 1'b1);
        pin = 1'b0; idle(4);
        check("R5 deemph low", deemph, 1'b0);

        // R6: external mode masks de-emphasis
        pulses(16); idle(4);
        check("R6 entered ext", ext_mode, 1'b1);
        pin = 1'b1; idle(6);
        check("R6 deemph masked", deemph, 1'b0);
        pin = 1'b0; idle(4);

        // R7 / R9: timeout stepped edge by edge
        flip_frame();   // rise 1
        check("R7 still ext after one rise", ext_mode, 1'b1);
        flip_frame();   // fall
        check("R9 fall does not count", ext_mode, 1'b1);
        flip_frame();   // rise 2
        check("R7 back to internal", ext_mode, 1'b0);
        pin = 1'b1; idle(4);
        check("R5 deemph returns", deemph, 1'b1);
        pin = 1'b0; idle(4);

        // R8: pin edge restarts the timeout
        do_reset(1'b0);
        pulses(16); idle(4);
        check("R8 entered ext", ext_mode, 1'b1);
        flip_frame();   // rise 1
        flip_frame();   // fall
        pulses(1);
        flip_frame();   // rise, count restarted so this is 1
        check("R8 held by edge", ext_mode, 1'b1);
        flip_frame();
        flip_frame();   // rise 2 after edge
        check("R8 expires after restart", ext_mode, 1'b0);

        // R10: running clock over several frames
        do_reset(1'b0);
        pulses(16); idle(2);
        for (int f = 0; f < 4; f++) begin
            flip_frame(); pulses(8);
            flip_frame(); pulses(8);
            check($sformatf("R10 frame %0d", f), ext_mode, 1'b1);
        end

        // R1: reset from external mode
        @(negedge clk); rst = 1'b1;
        idle(2);
        check("R1 reset clears ext", ext_mode, 1'b0);
        rst = 1'b0; idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule